// File: doc/BRIEF.md
# Timer Pin Controller with Level Output and Edge Capture

This block controls the single IO pin of one timer channel. A packed mode register decides what the pin does. In general-purpose mode the pin is either a plain input or drives a fixed level, and an open-drain option makes a high level release the pin rather than drive it. In capture mode the block watches the synchronized pin for the selected edges, raises event flags in a status register and can request an interrupt. On each qualifying edge it also latches a free-running counter into a capture register.

Software reaches the block through one small register port. Address 0 is the mode register, address 1 is the status register and address 2 is the capture register. Reads are combinational on the address. The synchronized pin level can always be read back in the status register. The pin is driven only when general-purpose drive is selected and edge interrupts are off.

Top module: `tpin_ctrl`

## Requirements
- R1: After reset the mode register, the status flags, the capture register and the counter are zero. pin_oe, pin_o and irq_o are low.
- R2: The mode register (address 0) keeps only bits 2:0 (function select), 5:4 (drive control), 8 (interrupt enable), 9 (open drain) and 17:16 (edge select). All other bits read as zero. Address 3 reads as zero, and writes to address 2 or 3 change nothing.
- R3: With function 4 (general-purpose) and bit 8 clear, drive code 10 drives low (pin_oe=1, pin_o=0), code 11 drives high (pin_oe=1, pin_o=1), and codes 00 and 01 leave the pin undriven. pin_o is 0 whenever pin_oe is 0.
- R4: With bit 9 set, a high drive level releases the pin (pin_oe=0), while a low level is still driven.
- R5: The pin is never driven when bit 8 is set or the function select is not 4. The drive code is then ignored.
- R6: Status bit 8 shows pin_i after a two-stage synchronizer, so it is visible two clocks after the pin changes.
- R7: With function 1 (capture), edge select 01 detects rising edges, 10 falling edges, 11 both and 00 none. A detected edge sets status bit 0 on the third clock after the pin change, and also sets bit 1 for a rising edge or bit 2 for a falling edge.
- R8: Status bit 3 (overrun) is set when an edge is detected while status bit 0 is already set.
- R9: Writing status (address 1) clears each of bits 3:0 where the written data has a 1. An edge arriving in the same cycle wins over the clear.
- R10: irq_o is high exactly when mode bit 8 and status bit 0 are both set.
- R11: A CNT_W-bit counter starts at 0 after reset and increments every clock, wrapping at its width. On each detected edge its current value is copied to the capture register (address 2, zero-extended).
- R12: Pin edges are not detected in any function other than capture, whatever the edge select holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 status, 2 capture |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pin_i | input | 1 | Pin level from the pad |
| pin_o | output | 1 | Level to drive on the pin |
| pin_oe | output | 1 | Pin output enable |
| irq_o | output | 1 | Edge interrupt request |

## Verification
The bench builds the block with CNT_W set to 8 and two synchronizer stages. The narrow counter wraps many times within a short run, so the wrap of captured values and the counter's step across its width are both checked. The two-stage setting fixes the third-clock edge latency that the reference model's timing relies on, including the corner where an edge and a clearing write land in the same cycle.

// File: rtl/tpin_pkg.sv
package tpin_pkg;
    localparam int REG_W       = 32;
    localparam int FN_LSB      = 0;
    localparam int DRV_LSB     = 4;
    localparam int IRQEN_BIT   = 8;
    localparam int OD_BIT      = 9;
    localparam int EDGE_LSB    = 16;
    localparam int LVL_BIT     = 8;
    localparam int FLAG_W      = 4;

    localparam logic [2:0] FN_OFF  = 3'd0;
    localparam logic [2:0] FN_CAPT = 3'd1;
    localparam logic [2:0] FN_GPIO = 3'd4;

    localparam logic [REG_W-1:0] MODE_KEEP = 32'h0003_0337;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CAPT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tpin_edge.sv
module tpin_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       rise,
    output logic       fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = en && sel[0] &&  lvl && !prev_q;
        fall   = en && sel[1] && !lvl &&  prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
    import tpin_pkg::*;
(
    input  logic [REG_W-1:0] mode,
    output logic             pin_o,
    output logic             pin_oe
);
    logic drive_en, level_hi;

    always_comb begin
        drive_en = (mode[FN_LSB+:3] == FN_GPIO) && !mode[IRQEN_BIT] && mode[DRV_LSB+1];
        level_hi = mode[DRV_LSB];
        pin_oe   = drive_en && !(mode[OD_BIT] && level_hi);
        pin_o    = pin_oe && level_hi;
    end
endmodule

// File: rtl/tpin_ctrl.sv
module tpin_ctrl
    import tpin_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             pin_i,
    output logic             pin_o,
    output logic             pin_oe,
    output logic             irq_o
);
    typedef struct packed {
        logic [REG_W-1:0]  mode;
        logic [FLAG_W-1:0] flags;
        logic [CNT_W-1:0]  cap;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t st_d, st_q;

    logic             lvl, rise, fall, evt;
    logic [FLAG_W-1:0] clr;
    logic [REG_W-1:0] mode_q;
    logic [FLAG_W-1:0] flags_q;
    logic [CNT_W-1:0] cnt_q;

    assign mode_q  = st_q.mode;
    assign flags_q = st_q.flags;
    assign cnt_q   = st_q.cnt;

    tpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_i),
        .q    (lvl)
    );

    tpin_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .en   (st_q.mode[FN_LSB+:3] == FN_CAPT),
        .sel  (st_q.mode[EDGE_LSB+:2]),
        .rise (rise),
        .fall (fall)
    );

    tpin_drive u_drive (
        .mode  (st_q.mode),
        .pin_o (pin_o),
        .pin_oe(pin_oe)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        evt      = rise || fall;
        clr      = (reg_we && reg_addr == SEL_STAT) ? reg_wdata[FLAG_W-1:0] : '0;

        if (reg_we && reg_addr == SEL_MODE)
            st_d.mode = reg_wdata & MODE_KEEP;

        st_d.flags = st_q.flags & ~clr;
        if (evt) begin
            st_d.flags[0] = 1'b1;
            st_d.flags[1] = st_d.flags[1] | rise;
            st_d.flags[2] = st_d.flags[2] | fall;
            st_d.flags[3] = st_d.flags[3] | st_q.flags[0];
            st_d.cap      = st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            SEL_MODE: reg_rdata = st_q.mode;
            SEL_STAT: begin
                reg_rdata[FLAG_W-1:0] = st_q.flags;
                reg_rdata[LVL_BIT]    = lvl;
            end
            SEL_CAPT: reg_rdata[CNT_W-1:0] = st_q.cap;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_o = st_q.mode[IRQEN_BIT] && st_q.flags[0];
endmodule

// File: rtl/tpin_ctrl_chk.sv
module tpin_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pin_o,
    input logic              pin_oe,
    input logic              irq_o,
    input logic [31:0]       mode_q,
    input logic [3:0]        flags_q,
    input logic [CNT_W-1:0]  cnt_q
);
    // R5
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> (mode_q[2:0] == 3'd4 && !mode_q[8]));

    // R4
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && mode_q[9]) |-> !pin_o);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mode_q[8] && flags_q[0]));

    // R12
    evt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[0]) |-> ($past(mode_q[2:0]) == 3'd1));

    // R8
    overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[3]) |-> $past(flags_q[0]));

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

bind tpin_ctrl tpin_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_o  (pin_o),
    .pin_oe (pin_oe),
    .irq_o  (irq_o),
    .mode_q (mode_q),
    .flags_q(flags_q),
    .cnt_q  (cnt_q)
);

// File: tb/test_tpin_ctrl.sv
module test_tpin_ctrl;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pin_i = 1'b0;
    logic        pin_o, pin_oe, irq_o;

    tpin_ctrl #(.CNT_W(CW), .SYNC_STAGES(2)) i_tpin_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    string tag = "R1 reset";
    int    rot = 0;

    // reference model state
    int m_mode = 0, m_flags = 0, m_cap = 0, m_cnt = 0;
    int s1 = 0, s2 = 0, s3 = 0;
    int t_fn, t_clr, t_nf;
    bit t_rise, t_fall;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_flags = 0; m_cap = 0; m_cnt = 0;
            s1 = 0; s2 = 0; s3 = 0;
        end else begin
            t_fn   = m_mode & 7;
            t_rise = (t_fn == 1) && ((m_mode >> 16) & 1) != 0 && s2 == 1 && s3 == 0;
            t_fall = (t_fn == 1) && ((m_mode >> 17) & 1) != 0 && s2 == 0 && s3 == 1;
            t_clr  = (reg_we && reg_addr == 2'd1) ? int'(reg_wdata[3:0]) : 0;
            t_nf   = m_flags & ~t_clr;
            if (t_rise || t_fall) begin
                t_nf = t_nf | 1;
                if (t_rise) t_nf = t_nf | 2;
                if (t_fall) t_nf = t_nf | 4;
                if ((m_flags & 1) != 0) t_nf = t_nf | 8;
                m_cap = m_cnt;
            end
            m_flags = t_nf & 15;
            m_cnt = (m_cnt + 1) % (1 << CW);
            if (reg_we && reg_addr == 2'd0) m_mode = int'(reg_wdata & 32'h0003_0337);
            s3 = s2; s2 = s1; s1 = int'(pin_i);
        end
    end

    task automatic check1(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        int fn, drv, e_oe, e_o;
        logic [31:0] e_rd;
        fn   = m_mode & 7;
        drv  = (fn == 4 && ((m_mode >> 8) & 1) == 0 && ((m_mode >> 5) & 1) == 1) ? 1 : 0;
        e_oe = (drv == 1 && !(((m_mode >> 9) & 1) == 1 && ((m_mode >> 4) & 1) == 1)) ? 1 : 0;
        e_o  = (e_oe == 1 && ((m_mode >> 4) & 1) == 1) ? 1 : 0;
        case (reg_addr)
            2'd0:    e_rd = 32'(m_mode);
            2'd1:    e_rd = 32'((s2 << 8) | m_flags);
            2'd2:    e_rd = 32'(m_cap);
            default: e_rd = 32'd0;
        endcase
        check1("pin_oe", {31'd0, pin_oe}, 32'(e_oe));
        check1("pin_o",  {31'd0, pin_o},  32'(e_o));
        check1("irq_o",  {31'd0, irq_o},
               32'((((m_mode >> 8) & 1) == 1 && (m_flags & 1) == 1) ? 1 : 0));
        check1("reg_rdata", reg_rdata, e_rd);
    endtask

    task automatic tick(bit we, logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        compare();
        reg_we = we; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            tick(1'b0, 2'(rot), '0);
            rot = (rot + 1) % 4;
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        tick(1'b1, a, d);
        idle(1);
    endtask

    task automatic pin_step(bit v, int n);
        pin_i = v;
        idle(n);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1 reset";
        idle(6);

        tag = "R2 mode fields";
        wr(2'd0, 32'hFFFF_FFFF); idle(4);
        wr(2'd2, 32'hFFFF_FFFF); wr(2'd3, 32'h1234_5678); idle(4);
        wr(2'd0, 32'h0);

        tag = "R3 gpio drive";
        wr(2'd0, 32'h24); idle(4);
        wr(2'd0, 32'h34); idle(4);
        wr(2'd0, 32'h04); idle(4);
        wr(2'd0, 32'h14); idle(4);

        tag = "R4 open drain";
        wr(2'd0, 32'h234); idle(4);
        wr(2'd0, 32'h224); idle(4);

        tag = "R5 drive ignored";
        wr(2'd0, 32'h134); idle(4);
        wr(2'd0, 32'h31);  idle(4);
        wr(2'd0, 32'h33);  idle(4);

        tag = "R6 level readback";
        wr(2'd0, 32'h4);
        pin_step(1'b1, 5); pin_step(1'b0, 5); pin_step(1'b1, 1); pin_step(1'b0, 4);

        tag = "R12 no edges outside capture";
        wr(2'd0, 32'h0003_0004);
        pin_step(1'b1, 5); pin_step(1'b0, 5);
        wr(2'd0, 32'h0003_0000);
        pin_step(1'b1, 5); pin_step(1'b0, 5);

        tag = "R7 rising";
        wr(2'd0, 32'h0001_0001);
        pin_step(1'b1, 6); wr(2'd1, 32'hF); pin_step(1'b0, 6);
        tag = "R7 falling";
        wr(2'd0, 32'h0002_0001);
        pin_step(1'b1, 6); pin_step(1'b0, 6); wr(2'd1, 32'hF);
        tag = "R7 both";
        wr(2'd0, 32'h0003_0001);
        pin_step(1'b1, 6); pin_step(1'b0, 6); wr(2'd1, 32'hF);
        tag = "R7 none";
        wr(2'd0, 32'h0000_0001);
        pin_step(1'b1, 6); pin_step(1'b0, 6);

        tag = "R8 overrun";
        wr(2'd0, 32'h0003_0001);
        pin_step(1'b1, 2); pin_step(1'b0, 6);
        tag = "R9 partial clear";
        wr(2'd1, 32'h8); idle(2);
        wr(2'd1, 32'h2); idle(2);
        wr(2'd1, 32'hF); idle(2);
        tag = "R9 set beats clear";
        pin_i = 1'b1; idle(2); wr(2'd1, 32'hF); idle(4);
        wr(2'd1, 32'hF);

        tag = "R10 interrupt";
        wr(2'd0, 32'h0003_0101);
        pin_step(1'b0, 6); wr(2'd1, 32'h1); idle(3);
        wr(2'd0, 32'h0003_0001); pin_step(1'b1, 6);
        wr(2'd0, 32'h0003_0101); idle(3); wr(2'd1, 32'hF); idle(3);

        tag = "R11 capture and wrap";
        for (int k = 0; k < 20; k++) begin
            pin_step(~pin_i, 7 + k * 5);
        end

        tag = "R7 R8 R9 R11 mixed";
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 5) pin_i = ~pin_i;
            if (r == 6) tick(1'b1, 2'd1, 32'($urandom % 16));
            else if (r == 7) tick(1'b1, 2'd0, ($urandom & 32'h0003_0337) | 32'h1);
            else idle(1);
        end

        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog %s: actual timeout expected completion", tag);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule